// File: doc/BRIEF.md
# Dual-Role Byte SPI Controller

This block is a byte-wide SPI engine that can run as bus master or as bus slave. Software controls it through three small registers: a control byte, a status byte and a data byte. As master it makes the serial clock from the system clock with one of four dividers. It shifts the written byte out on MOSI and, at the same time, takes a byte in from MISO. As slave it follows an outside clock and an active-low select input. It shifts its loaded byte out on MISO and takes in the byte on MOSI.

Each finished byte goes into a receive buffer that is kept apart from the shift register. The finished byte also sets a sticky completion flag, which drives the interrupt line. A write to the data register while a byte is moving sets a sticky collision flag. That write changes nothing in the byte on the wire. Clock polarity, clock phase and bit order are control bits. Every pin has an output enable, so the block can hand its pins back to general use.

Top module: `spi_dual_ctrl`

## Requirements
- R1: After reset, no output enable is active, `irq` is 0, the status byte reads 0 and the data register reads 0.
- R2: With the enable bit low, `sclk_oe`, `mosi_oe` and `miso_oe` are all 0.
- R3: Register map: address 0 is control, address 1 is status and address 2 is data. A data write reads back the receive buffer.
- R4: Control bit fields are: bit 0 enable, bit 1 master, bit 2 ignore-select, bit 3 LSB-first, bit 4 CPOL, bit 5 CPHA and bits 7:6 rate. The rate field selects divide by 4, 16, 64 or 128. As master, each clock half period lasts divider/2 system clocks, a byte is 16 half periods, and the clock rests at CPOL both before and after the byte.
- R5: As master, a data write while idle starts a transfer. The written byte appears on MOSI and the MISO byte lands in the receive buffer. With CPHA=0, bits are sampled on the leading edge. With CPHA=1, bits are sampled on the trailing edge. With LSB-first=1, bit 0 goes first; otherwise bit 7 goes first.
- R6: The master role is active when enable=1, master=1, and either ignore-select=1 or `ssel_n_i`=1. In the master role, `sclk_oe`=`mosi_oe`=1 and `miso_oe`=0. Otherwise, with enable=1, the slave is selected when ignore-select=1 or `ssel_n_i`=0. A selected slave has `miso_oe`=1 and `sclk_oe`=`mosi_oe`=0.
- R7: As a selected slave, the byte loaded by a data write while idle goes out on MISO, and the byte on MOSI lands in the receive buffer. Both use the same phase and order rules as R5.
- R8: If the slave is deselected before the eighth bit, the partial byte is dropped and the bit count resets. The completion flag stays clear, and the next full byte transfers correctly.
- R9: Status bit 0 is the completion flag. It is set when a byte finishes and it drives `irq`. Writing 1 to the bit clears it, and clearing it drops `irq`.
- R10: Status bit 1 is the collision flag. It is set by a data write during a transfer and is cleared by writing 1 to it. The colliding write neither alters nor stops the byte in flight.
- R11: The receive buffer changes only when a byte completes. A data write that loads the shifter does not change what the data address reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request, follows completion flag |
| sclk_i | input | 1 | Serial clock from pad (slave) |
| sclk_o | output | 1 | Serial clock to pad (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI from pad (slave) |
| mosi_o | output | 1 | MOSI to pad (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from pad (master) |
| miso_o | output | 1 | MISO to pad (slave) |
| miso_oe | output | 1 | MISO output enable |
| ssel_n_i | input | 1 | Active-low slave select |

## Verification
The assertions check these on every cycle:
- Pins stay quiet while the block is disabled.
- The master and slave drive sets never overlap.
- The clock returns to its rest level when a master byte ends.
- The shifter is loaded only while idle.
- A colliding write never cuts short a transfer.
- The interrupt and the receive buffer move only when a byte completes.

Only the bench scenarios can show the byte values that cross the wire for each phase, order and rate combination. The same holds for the exact half period of each divider, the behaviour after a slave is dropped mid-byte, and the flag clearing done by software.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       lsb_first;
    logic       ign_sel;
    logic       master;
    logic       enable;
  } spi_ctrl_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned    W       = 3,
  parameter int unsigned    STAGES  = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] s_last,
  output logic [W-1:0] s_prev
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_next
      always_comb stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign s_last = stage_q[STAGES-2];
  assign s_prev = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int unsigned DIV0 = 4,
  parameter int unsigned DIV1 = 16,
  parameter int unsigned DIV2 = 64,
  parameter int unsigned DIV3 = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int unsigned CNT_W = $clog2(DIV3 / 2);
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'(DIV0 / 2 - 1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(DIV1 / 2 - 1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(DIV2 / 2 - 1);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'(DIV3 / 2 - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    case (rate)
      2'd0:    limit = LIM0;
      2'd1:    limit = LIM1;
      2'd2:    limit = LIM2;
      default: limit = LIM3;
    endcase
  end

  assign tick = run && (cnt_q == limit);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_byte,
  input  logic             abort,
  input  logic             lead,
  input  logic             trail,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             in_bit,
  output logic             out_bit,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] rx_byte
);
  localparam int unsigned CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] sh_q, sh_d, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mid_q, mid_d, samp_q, samp_d, ins;

  assign ins     = cpha ? in_bit : samp_q;
  assign shifted = lsb_first ? {ins, sh_q[WIDTH-1:1]} : {sh_q[WIDTH-2:0], ins};
  assign out_bit = lsb_first ? sh_q[0] : sh_q[WIDTH-1];
  assign busy    = (cnt_q != '0) || mid_q;
  assign done    = trail && !abort && !load && (cnt_q == LAST);
  assign rx_byte = shifted;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    mid_d  = mid_q;
    samp_d = samp_q;
    if (load) begin
      sh_d  = load_byte;
      cnt_d = '0;
      mid_d = 1'b0;
    end else if (abort) begin
      cnt_d = '0;
      mid_d = 1'b0;
    end else if (trail) begin
      sh_d  = shifted;
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      mid_d = 1'b0;
    end else if (lead) begin
      mid_d = 1'b1;
      if (!cpha) samp_d = in_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      mid_q  <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      mid_q  <= mid_d;
      samp_q <= samp_d;
    end
  end

  // R10: a new byte may only enter the shifter between transfers
  assert_load_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
  import spi_dual_pkg::*;
#(
  parameter int unsigned DIV0 = 4,
  parameter int unsigned DIV1 = 16,
  parameter int unsigned DIV2 = 64,
  parameter int unsigned DIV3 = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ssel_n_i
);
  // reset: asserted asynchronously, released on the clock
  logic rst_a_q, rst_b_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  logic rst_q;
  assign rst_q = rst_b_q;

  // pad input synchronisers: {ssel_n, mosi, sclk}
  logic [2:0] pin_last, pin_prev;
  spi_pin_sync #(.W(3), .STAGES(3), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_q), .din({ssel_n_i, mosi_i, sclk_i}),
    .s_last(pin_last), .s_prev(pin_prev)
  );
  logic sclk_s, sclk_s_old, mosi_s_old, ssel_n_s;
  assign sclk_s     = pin_last[0];
  assign sclk_s_old = pin_prev[0];
  assign mosi_s_old = pin_prev[1];
  assign ssel_n_s   = pin_last[2];

  // registers
  spi_ctrl_t         ctrl_q, ctrl_d;
  logic              done_q, done_d, wcol_q, wcol_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;
  logic              m_busy_q, m_busy_d, sclk_q, sclk_d;

  // roles
  logic role_master, slave_sel;
  assign role_master = ctrl_q.enable && ctrl_q.master && (ctrl_q.ign_sel || ssel_n_s);
  assign slave_sel   = ctrl_q.enable && !role_master && (ctrl_q.ign_sel || !ssel_n_s);

  // shifter control
  logic sh_busy, sh_done, sh_out, tick;
  logic [DATA_W-1:0] sh_rx;
  logic xfer_busy, data_wr, stat_wr, ctrl_wr, load, abort;
  logic m_lead, m_trail, s_edge, s_lead, s_trail, in_bit;

  assign xfer_busy = m_busy_q || sh_busy;
  assign data_wr   = wr_en && (wr_addr == ADDR_DATA);
  assign stat_wr   = wr_en && (wr_addr == ADDR_STAT);
  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign load      = data_wr && !xfer_busy && ctrl_q.enable;
  assign abort     = (!role_master && !slave_sel) || (m_busy_q && !role_master);

  assign m_lead  = m_busy_q && tick && (sclk_q == ctrl_q.cpol);
  assign m_trail = m_busy_q && tick && (sclk_q != ctrl_q.cpol);
  assign s_edge  = slave_sel && (sclk_s != sclk_s_old);
  assign s_lead  = s_edge && (sclk_s != ctrl_q.cpol);
  assign s_trail = s_edge && (sclk_s == ctrl_q.cpol);
  assign in_bit  = role_master ? miso_i : mosi_s_old;

  spi_rate_div #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) i_div (
    .clk(clk), .rst_n(rst_q), .run(m_busy_q), .rate(ctrl_q.rate), .tick(tick)
  );

  spi_bit_shifter #(.WIDTH(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_q), .load(load), .load_byte(wr_data), .abort(abort),
    .lead(m_lead || s_lead), .trail(m_trail || s_trail),
    .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first), .in_bit(in_bit),
    .out_bit(sh_out), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx)
  );

  // next state
  always_comb begin
    ctrl_d   = ctrl_wr ? spi_ctrl_t'(wr_data) : ctrl_q;
    done_d   = sh_done || (done_q && !(stat_wr && wr_data[0]));
    wcol_d   = (data_wr && xfer_busy) || (wcol_q && !(stat_wr && wr_data[1]));
    rxbuf_d  = sh_done ? sh_rx : rxbuf_q;
    if (!role_master)                m_busy_d = 1'b0;
    else if (load)                   m_busy_d = 1'b1;
    else if (sh_done)                m_busy_d = 1'b0;
    else                             m_busy_d = m_busy_q;
    if (!m_busy_q)                   sclk_d = ctrl_q.cpol;
    else if (tick)                   sclk_d = !sclk_q;
    else                             sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q   <= '0;
      done_q   <= 1'b0;
      wcol_q   <= 1'b0;
      rxbuf_q  <= '0;
      m_busy_q <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      done_q   <= done_d;
      wcol_q   <= wcol_d;
      rxbuf_q  <= rxbuf_d;
      m_busy_q <= m_busy_d;
      sclk_q   <= sclk_d;
    end
  end

  // outputs
  assign irq     = done_q;
  assign sclk_o  = sclk_q;
  assign sclk_oe = role_master;
  assign mosi_o  = sh_out;
  assign mosi_oe = role_master;
  assign miso_o  = sh_out;
  assign miso_oe = slave_sel;

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = ctrl_q;
      ADDR_STAT: rd_data = {{(DATA_W-2){1'b0}}, wcol_q, done_q};
      ADDR_DATA: rd_data = rxbuf_q;
      default:   rd_data = '0;
    endcase
  end

  assert_pins_quiet_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !ctrl_q.enable |-> !(sclk_oe || mosi_oe || miso_oe));
  assert_one_role_R6: assert property (@(posedge clk) disable iff (!rst_q)
    !(sclk_oe && miso_oe));
  assert_clock_rests_R4: assert property (@(posedge clk) disable iff (!rst_q)
    ($fell(m_busy_q) && role_master) |-> (sclk_q == ctrl_q.cpol));
  assert_irq_from_done_R9: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(irq) |-> $past(sh_done));
  assert_rxbuf_only_done_R11: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(rxbuf_q) |-> $past(sh_done));
  assert_collision_keeps_xfer_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (data_wr && m_busy_q && role_master && !sh_done) |=> m_busy_q);
endmodule

// File: tb/test_spi_dual_ctrl.sv
`timescale 1ns/1ps
module test_spi_dual_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd1;
  logic [7:0] wr_data = 8'd0, rd_data;
  logic       irq, sclk_i = 1'b0, sclk_o, sclk_oe, mosi_i = 1'b0, mosi_o, mosi_oe;
  logic       miso_i, miso_o, miso_oe, ssel_n_i = 1'b1;

  spi_dual_ctrl i_spi_dual_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ssel_n_i(ssel_n_i)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  bit        c_cpol = 0, c_cpha = 0, c_lsb = 0, exp_master = 0;
  int        m_half = 2;
  bit        m_active = 0;
  int        m_cnt = 0;
  logic [7:0] peer_tx = 8'h00, peer_rx = 8'h00;
  int        peer_idx = 0;
  logic      last_sclk = 1'b0, prev_mosi = 1'b0;

  assign miso_i = c_lsb ? peer_tx[peer_idx] : peer_tx[7-peer_idx];

  always @(posedge clk) begin
    if (!m_active && exp_master && wr_en && wr_addr == 2'd2) begin
      m_active <= 1'b1;
      m_cnt    <= 0;
    end else if (m_active && m_cnt == 16*m_half) begin
      m_active <= 1'b0;
    end else if (m_active) begin
      m_cnt <= m_cnt + 1;
    end
  end

  // peer slave plus per-cycle clock comparison
  always @(negedge clk) begin
    if (m_active) begin
      if (m_cnt == 0) begin
        peer_idx = 0;
        peer_rx  = 8'h00;
      end else if (sclk_o !== last_sclk) begin
        bit lead;
        lead = (sclk_o != c_cpol);
        if (lead ^ c_cpha)
          peer_rx = c_lsb ? {prev_mosi, peer_rx[7:1]} : {peer_rx[6:0], prev_mosi};
        if (!lead && peer_idx < 7) peer_idx++;
      end
      if (m_cnt < 16*m_half)
        check(sclk_o == (c_cpol ^ ((m_cnt / m_half) % 2)), "R4 sclk level", sclk_o,
              c_cpol ^ ((m_cnt / m_half) % 2));
      else begin
        check(sclk_o == c_cpol, "R4 clock rests after byte", sclk_o, c_cpol);
        check(rd_data[0] == 1'b1, "R9 completion flag", rd_data[0], 1);
      end
    end
    last_sclk = sclk_o;
    prev_mosi = mosi_o;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    wr(2'd1, 8'h03);
    rd_addr = 2'd1; #1;
    check(rd_data == 8'h00, "R9 R10 flags clear by write-1", rd_data, 0);
    check(irq == 1'b0, "R9 irq drops", irq, 0);
  endtask

  task automatic master_xfer(input logic [1:0] rate, input bit cpol, input bit cpha,
                             input bit lsb, input logic [7:0] tx, input logic [7:0] ptx,
                             input bit collide);
    c_cpol = cpol; c_cpha = cpha; c_lsb = lsb;
    m_half = (rate == 0) ? 2 : (rate == 1) ? 8 : (rate == 2) ? 32 : 64;
    peer_tx = ptx;
    wr(2'd0, {rate, cpha, cpol, lsb, 1'b1, 1'b1, 1'b1});
    idle(2);
    check(sclk_oe && mosi_oe && !miso_oe, "R6 master drives", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
    check(sclk_o == cpol, "R4 idle level", sclk_o, cpol);
    exp_master = 1'b1;
    rd_addr = 2'd1;
    wr(2'd2, tx);
    if (collide) begin
      idle(4*m_half);
      wr(2'd2, ~tx);
    end
    while (m_active) @(negedge clk);
    exp_master = 1'b0;
    check(peer_rx == tx, "R5 byte sent on MOSI", peer_rx, tx);
    rd_addr = 2'd2; #1;
    check(rd_data == ptx, "R5 byte received into buffer", rd_data, ptx);
    check(irq == 1'b1, "R9 irq raised", irq, 1);
    rd_addr = 2'd1; #1;
    check(rd_data[1] == collide, "R10 collision flag", rd_data[1], collide);
    clear_flags();
  endtask

  task automatic slave_xfer(input bit cpol, input bit cpha, input bit lsb,
                            input logic [7:0] dtx, input logic [7:0] btx, input int nbits);
    logic [7:0] got = 8'h00, old_buf;
    c_cpol = cpol; c_cpha = cpha; c_lsb = lsb;
    sclk_i = cpol; ssel_n_i = 1'b1;
    wr(2'd0, {2'b00, cpha, cpol, lsb, 1'b0, 1'b0, 1'b1});
    idle(4);
    rd_addr = 2'd2; #1; old_buf = rd_data;
    wr(2'd2, dtx);
    ssel_n_i = 1'b0;
    idle(6);
    check(miso_oe && !sclk_oe && !mosi_oe, "R6 slave drives MISO only", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = lsb ? btx[i] : btx[7-i];
      idle(8);
      if (!cpha) got = lsb ? {miso_o, got[7:1]} : {got[6:0], miso_o};
      sclk_i = ~cpol;
      idle(8);
      if (cpha) got = lsb ? {miso_o, got[7:1]} : {got[6:0], miso_o};
      sclk_i = cpol;
      idle(8);
    end
    ssel_n_i = 1'b1;
    idle(6);
    rd_addr = 2'd2; #1;
    if (nbits == 8) begin
      check(got == dtx, "R7 slave byte on MISO", got, dtx);
      check(rd_data == btx, "R7 slave byte into buffer", rd_data, btx);
      check(irq == 1'b1, "R9 irq after slave byte", irq, 1);
      clear_flags();
    end else begin
      check(rd_data == old_buf, "R8 partial byte dropped", rd_data, old_buf);
      check(irq == 1'b0, "R8 no completion on abort", irq, 0);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check(!sclk_oe && !mosi_oe && !miso_oe, "R1 no pin driven", {sclk_oe, mosi_oe, miso_oe}, 0);
    check(irq == 1'b0, "R1 irq low", irq, 0);
    rd_addr = 2'd1; #1; check(rd_data == 8'h00, "R1 status zero", rd_data, 0);
    rd_addr = 2'd2; #1; check(rd_data == 8'h00, "R1 buffer zero", rd_data, 0);
    // R2 disabled with master bit set
    wr(2'd0, 8'h06);
    idle(2);
    check(!sclk_oe && !mosi_oe && !miso_oe, "R2 disabled quiet", {sclk_oe, mosi_oe, miso_oe}, 0);
    rd_addr = 2'd0; #1; check(rd_data == 8'h06, "R3 control readback", rd_data, 8'h06);
    // master scenarios across rates, phase, polarity, order
    master_xfer(2'd0, 0, 0, 0, 8'hA5, 8'h3C, 0);
    master_xfer(2'd1, 1, 0, 1, 8'h81, 8'hE7, 0);
    master_xfer(2'd2, 0, 1, 0, 8'h5A, 8'h0F, 0);
    master_xfer(2'd3, 1, 1, 1, 8'hC3, 8'h96, 0);
    master_xfer(2'd1, 0, 0, 0, 8'h69, 8'hD2, 1);
    // R6 select pin forces slave when not ignored
    wr(2'd0, 8'h03);
    ssel_n_i = 1'b0;
    idle(5);
    check(!sclk_oe && miso_oe, "R6 select forces slave", {sclk_oe, miso_oe}, 2'b01);
    ssel_n_i = 1'b1;
    idle(5);
    check(sclk_oe && !miso_oe, "R6 master with select high", {sclk_oe, miso_oe}, 2'b10);
    // slave scenarios
    slave_xfer(0, 0, 0, 8'h4B, 8'hB1, 8);
    slave_xfer(1, 1, 1, 8'h27, 8'h9E, 8);
    slave_xfer(0, 1, 0, 8'h11, 8'hFF, 3);
    slave_xfer(0, 1, 0, 8'hE8, 8'h72, 8);
    // R11 loading the shifter leaves the buffer alone
    wr(2'd2, 8'h55);
    rd_addr = 2'd2; #1;
    check(rd_data == 8'h72, "R11 buffer separate from shifter", rd_data, 8'h72);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule